// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual page number into a physical frame number when a translation cache has missed. The page table lives in memory as page-sized chunks of entries. A top-level directory either points at the chunk that covers a range of virtual pages or marks that whole chunk as absent. A client hands the walker a virtual page number together with the base address of the directory. The walker then issues one or two dependent reads on a single memory read port and replies with a frame number or a fault code.

The lookup is strictly sequential. The upper part of the page number selects a directory word. When that word is marked valid, its frame field locates a chunk, and the lower part of the page number selects a word inside that chunk. An absent chunk ends the walk after one read. Memory may take any number of cycles to answer each read. The requester keeps the response until it takes it.

Top module: `ptw_top`

## Requirements
- R1: After a synchronous active-high reset, `req_ready` is 1, and `resp_valid` and `mem_rd_en` are 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after that until the response handshake completes, and `req_valid` asserted during that time starts no read.
- R3: In the cycle after a request is taken, `mem_rd_en` is 1 for one cycle with `mem_rd_addr` = `req_dir_base` + 4 × `req_vpn[7:4]`. Request inputs are captured when the request is taken.
- R4: Bit 31 of a directory or table word is its valid bit, and bits 19:0 hold a frame number. When the directory word is valid, a second single-cycle read is issued in the cycle after it returns, at (frame × 64) + 4 × `req_vpn[3:0]`.
- R5: A directory word with bit 31 clear ends the walk with no second read. The response carries `resp_status` = 2'b01 and `resp_frame` = 0, whatever the word's other bits hold.
- R6: A valid table word gives `resp_status` = 2'b00, with `resp_frame` equal to that word's bits 19:0.
- R7: A table word with bit 31 clear gives `resp_status` = 2'b10 and `resp_frame` = 0.
- R8: After each read the walker waits any number of cycles for `mem_rd_valid`. A `mem_rd_valid` pulse arriving while no read is pending changes no output and no later result.
- R9: `resp_valid` is raised in the cycle after the deciding read returns. It stays 1, with `resp_status` and `resp_frame` stable, until `resp_ready` is 1. `req_ready` returns in the next cycle.
- R10: At most one read is outstanding, and `mem_rd_en` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpn | input | 8 | Virtual page number to translate |
| req_dir_base | input | 32 | Byte address of the page directory |
| resp_valid | output | 1 | Walk result present |
| resp_ready | input | 1 | Requester takes the result |
| resp_status | output | 2 | 00 found, 01 directory fault, 10 table-entry fault |
| resp_frame | output | 20 | Physical frame number, 0 on a fault |
| mem_rd_en | output | 1 | Single-cycle read request |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rd_valid | input | 1 | Read data returned this cycle |
| mem_rd_data | input | 32 | Returned word |

## Verification
Two events can land in the same cycle. The first is a read return and a new request, or a stray read return, reaching the walker while it is holding a result. The second is the response handshake itself. The bench holds `req_valid` high and injects a lone `mem_rd_valid` pulse with a valid-looking word while `resp_ready` is held low. A behavioural model, updated every clock, then judges that no read starts, that the held status and frame do not move, and that the next walk returns the correct frame. Read latencies from zero to several cycles, and page numbers at both ends of the range, exercise the dependent second read against the early stop on an absent chunk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Walker phases
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DIR_RD   = 3'd1,
        ST_WAIT_DIR = 3'd2,
        ST_PTE_RD   = 3'd3,
        ST_WAIT_PTE = 3'd4,
        ST_RESP     = 3'd5
    } walk_state_e;

    // Result codes seen at the response port
    typedef enum logic [1:0] {
        WS_OK        = 2'b00,
        WS_DIR_FAULT = 2'b01,
        WS_PTE_FAULT = 2'b10
    } walk_status_e;

    // Default geometry
    localparam int unsigned PTW_VPN_W       = 8;
    localparam int unsigned PTW_TIDX_W      = 4;
    localparam int unsigned PTW_ADDR_W      = 32;
    localparam int unsigned PTW_DATA_W      = 32;
    localparam int unsigned PTW_FRAME_W     = 20;
    localparam int unsigned PTW_CHUNK_SHIFT = 6;
    localparam int unsigned PTW_ENTRY_SHIFT = 2;

    function automatic logic is_read_phase(input walk_state_e s);
        return (s == ST_DIR_RD) || (s == ST_PTE_RD);
    endfunction

endpackage

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FRAME_W = 20
) (
    input  logic [DATA_W-1:0]  word,
    output logic               ok,
    output logic [FRAME_W-1:0] frame
);
    localparam int unsigned VALID_BIT = DATA_W - 1;

    logic unused_mid;

    assign ok         = word[VALID_BIT];
    assign frame      = word[FRAME_W-1:0];
    assign unused_mid = ^word[VALID_BIT-1:FRAME_W];

    initial begin
        assert (FRAME_W < VALID_BIT)
            else $error("frame field overlaps valid bit");
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        rd_valid,
    input  logic        entry_ok,
    input  logic        resp_ready,
    output walk_state_e state,
    output logic        req_fire,
    output logic        dir_done,
    output logic        pte_done
);
    walk_state_e state_q, state_d;

    assign state    = state_q;
    assign req_fire = (state_q == ST_IDLE)     && req_valid;
    assign dir_done = (state_q == ST_WAIT_DIR) && rd_valid;
    assign pte_done = (state_q == ST_WAIT_PTE) && rd_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)  state_d = ST_DIR_RD;
            ST_DIR_RD:                   state_d = ST_WAIT_DIR;
            ST_WAIT_DIR: if (rd_valid)   state_d = entry_ok ? ST_PTE_RD : ST_RESP;
            ST_PTE_RD:                   state_d = ST_WAIT_PTE;
            ST_WAIT_PTE: if (rd_valid)   state_d = ST_RESP;
            ST_RESP:     if (resp_ready) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R8: a return in a waiting phase always moves the walk forward
    p_wait_advance_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_DIR || state_q == ST_WAIT_PTE) && rd_valid
        |=> state_q != ST_WAIT_DIR && state_q != ST_WAIT_PTE);

    // R8: without a return the walk stays where it is
    p_wait_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_DIR || state_q == ST_WAIT_PTE) && !rd_valid
        |=> $stable(state_q));
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int unsigned VPN_W       = 8,
    parameter int unsigned TIDX_W      = 4,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned FRAME_W     = 20,
    parameter int unsigned CHUNK_SHIFT = 6,
    parameter int unsigned ENTRY_SHIFT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  walk_state_e        state,
    input  logic               req_fire,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [ADDR_W-1:0]  req_base,
    input  logic               dir_load,
    input  logic [FRAME_W-1:0] dir_frame,
    output logic [ADDR_W-1:0]  rd_addr
);
    localparam int unsigned DIDX_W = VPN_W - TIDX_W;

    typedef struct packed {
        logic [DIDX_W-1:0] dir_idx;
        logic [TIDX_W-1:0] tbl_idx;
    } vpn_split_t;

    vpn_split_t          vpn_q;
    logic [ADDR_W-1:0]   base_q;
    logic [FRAME_W-1:0]  chunk_q;
    logic [ADDR_W-1:0]   dir_addr;
    logic [ADDR_W-1:0]   pte_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            vpn_q   <= '0;
            base_q  <= '0;
            chunk_q <= '0;
        end else begin
            if (req_fire) begin
                vpn_q  <= vpn_split_t'(req_vpn);
                base_q <= req_base;
            end
            if (dir_load) chunk_q <= dir_frame;
        end
    end

    assign dir_addr = base_q + (ADDR_W'(vpn_q.dir_idx) << ENTRY_SHIFT);
    assign pte_addr = (ADDR_W'(chunk_q) << CHUNK_SHIFT)
                    + (ADDR_W'(vpn_q.tbl_idx) << ENTRY_SHIFT);
    assign rd_addr  = (state == ST_PTE_RD) ? pte_addr : dir_addr;

    // R3: captured request fields do not move during a walk
    p_req_latched_r3: assert property (@(posedge clk) disable iff (rst)
        state != ST_IDLE |=> $stable(vpn_q) && $stable(base_q));
endmodule

// File: rtl/ptw_resp_reg.sv
module ptw_resp_reg
    import ptw_pkg::*;
#(
    parameter int unsigned FRAME_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dir_done,
    input  logic               pte_done,
    input  logic               entry_ok,
    input  logic [FRAME_W-1:0] entry_frame,
    output walk_status_e       status,
    output logic [FRAME_W-1:0] frame
);
    walk_status_e       status_q;
    logic [FRAME_W-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= WS_OK;
            frame_q  <= '0;
        end else if (dir_done && !entry_ok) begin
            status_q <= WS_DIR_FAULT;
            frame_q  <= '0;
        end else if (pte_done) begin
            status_q <= entry_ok ? WS_OK : WS_PTE_FAULT;
            frame_q  <= entry_ok ? entry_frame : '0;
        end
    end

    assign status = status_q;
    assign frame  = frame_q;

    // R6: the unused code never appears
    p_status_legal_r6: assert property (@(posedge clk) disable iff (rst)
        status_q != 2'b11);

    // R5 R7: the result holds when nothing concludes
    p_result_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !dir_done && !pte_done |=> $stable(status_q) && $stable(frame_q));
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int unsigned VPN_W       = PTW_VPN_W,
    parameter int unsigned TIDX_W      = PTW_TIDX_W,
    parameter int unsigned ADDR_W      = PTW_ADDR_W,
    parameter int unsigned DATA_W      = PTW_DATA_W,
    parameter int unsigned FRAME_W     = PTW_FRAME_W,
    parameter int unsigned CHUNK_SHIFT = PTW_CHUNK_SHIFT,
    parameter int unsigned ENTRY_SHIFT = PTW_ENTRY_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [ADDR_W-1:0]  req_dir_base,
    output logic               resp_valid,
    input  logic               resp_ready,
    output logic [1:0]         resp_status,
    output logic [FRAME_W-1:0] resp_frame,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [DATA_W-1:0]  mem_rd_data
);
    walk_state_e        state;
    logic               req_fire, dir_done, pte_done;
    logic               entry_ok;
    logic [FRAME_W-1:0] entry_frame;
    walk_status_e       status;

    ptw_entry_dec #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_dec (
        .word  (mem_rd_data),
        .ok    (entry_ok),
        .frame (entry_frame)
    );

    ptw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .rd_valid   (mem_rd_valid),
        .entry_ok   (entry_ok),
        .resp_ready (resp_ready),
        .state      (state),
        .req_fire   (req_fire),
        .dir_done   (dir_done),
        .pte_done   (pte_done)
    );

    ptw_addr_gen #(
        .VPN_W(VPN_W), .TIDX_W(TIDX_W), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W),
        .CHUNK_SHIFT(CHUNK_SHIFT), .ENTRY_SHIFT(ENTRY_SHIFT)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .req_fire  (req_fire),
        .req_vpn   (req_vpn),
        .req_base  (req_dir_base),
        .dir_load  (dir_done && entry_ok),
        .dir_frame (entry_frame),
        .rd_addr   (mem_rd_addr)
    );

    ptw_resp_reg #(.FRAME_W(FRAME_W)) u_resp (
        .clk         (clk),
        .rst         (rst),
        .dir_done    (dir_done),
        .pte_done    (pte_done),
        .entry_ok    (entry_ok),
        .entry_frame (entry_frame),
        .status      (status),
        .frame       (resp_frame)
    );

    assign req_ready   = (state == ST_IDLE);
    assign mem_rd_en   = is_read_phase(state);
    assign resp_valid  = (state == ST_RESP);
    assign resp_status = status;

    // R1: idle right after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> req_ready && !resp_valid && !mem_rd_en);

    // R2: a taken request closes the door and starts the directory read
    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> mem_rd_en && !req_ready);

    // R10: read pulses are single cycles
    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R10: handshake phases are mutually exclusive
    p_phases_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_ready, mem_rd_en, resp_valid}));

    // R9: result held under back-pressure
    p_resp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_ready
        |=> resp_valid && $stable(resp_status) && $stable(resp_frame));

    // R9: idle again after the handshake
    p_resp_exit_r9: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_ready |=> req_ready);

    // R5 R7: faults carry a zero frame
    p_fault_zero_r7: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_status != 2'b00 |-> resp_frame == '0);
endmodule

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_vpn = '0;
    logic [31:0] req_dir_base = '0;
    logic        resp_valid;
    logic        resp_ready = 1'b0;
    logic [1:0]  resp_status;
    logic [19:0] resp_frame;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;

    logic        rsp_v = 1'b0, stray_v = 1'b0;
    logic [31:0] rsp_d = '0, stray_d = '0;
    assign mem_rd_valid = rsp_v | stray_v;
    assign mem_rd_data  = rsp_v ? rsp_d : stray_d;

    int total = 0, bad = 0, nreads = 0, rsp_lat = 0;
    bit finished = 0;
    logic [31:0] mem [int unsigned];

    always #10 clk = ~clk;

    ptw_top u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_dir_base(req_dir_base), .resp_valid(resp_valid),
        .resp_ready(resp_ready), .resp_status(resp_status), .resp_frame(resp_frame),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory responder with programmable latency
    initial begin
        forever begin
            @(posedge clk);
            if (mem_rd_en) begin
                logic [31:0] a;
                a = mem_rd_addr;
                nreads++;
                repeat (rsp_lat) @(posedge clk);
                @(negedge clk);
                rsp_v = 1'b1;
                rsp_d = rd_word(a);
                @(negedge clk);
                rsp_v = 1'b0;
            end
        end
    end

    // behavioural reference: phase 0 idle,1 dir read,2 dir wait,3 entry read,4 entry wait,5 result
    int          m_ph = 0;
    logic [7:0]  m_vpn = '0;
    logic [31:0] m_base = '0, m_chunk = '0;
    logic [1:0]  m_st = '0;
    logic [19:0] m_fr = '0;

    always @(posedge clk) begin
        if (rst) m_ph <= 0;
        else if (m_ph == 0) begin
            if (req_valid) begin m_ph <= 1; m_vpn <= req_vpn; m_base <= req_dir_base; end
        end else if (m_ph == 1 || m_ph == 3) m_ph <= m_ph + 1;
        else if (m_ph == 2) begin
            if (mem_rd_valid) begin
                if (mem_rd_data[31]) begin
                    m_ph <= 3; m_chunk <= {12'h0, mem_rd_data[19:0]} * 64;
                end else begin
                    m_ph <= 5; m_st <= 2'b01; m_fr <= '0;
                end
            end
        end else if (m_ph == 4) begin
            if (mem_rd_valid) begin
                m_ph <= 5;
                m_st <= mem_rd_data[31] ? 2'b00 : 2'b10;
                m_fr <= mem_rd_data[31] ? mem_rd_data[19:0] : 20'h0;
            end
        end else if (resp_ready) m_ph <= 0;
    end

    // per-clock comparison, R2 R3 R4 R8 R9 R10
    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] ea;
            bit ok;
            ea = (m_ph == 1) ? m_base + 32'(m_vpn[7:4]) * 4
                             : m_chunk + 32'(m_vpn[3:0]) * 4;
            ok = (req_ready == (m_ph == 0)) && (mem_rd_en == (m_ph == 1 || m_ph == 3))
              && (resp_valid == (m_ph == 5));
            if (mem_rd_en && ok) ok = (mem_rd_addr == ea);
            if (resp_valid && ok) ok = (resp_status == m_st) && (resp_frame == m_fr);
            chk(ok, "R2/R3/R4/R8/R9/R10", "cycle model",
                {req_ready, mem_rd_en, resp_valid, resp_status, mem_rd_addr},
                {m_ph == 0, m_ph == 1 || m_ph == 3, m_ph == 5, m_st, ea});
        end
    end

    task automatic walk(input logic [7:0] vpn, input logic [31:0] base, input int lat,
                        input int hold, input bit poke, input logic [1:0] es,
                        input logic [19:0] ef, input int er, input string req);
        int guard;
        rsp_lat = lat;
        @(negedge clk);
        req_vpn = vpn; req_dir_base = base; req_valid = 1'b1; nreads = 0;
        @(negedge clk);
        req_valid = 1'b0; req_vpn = ~vpn; req_dir_base = ~base;   // R3 capture
        guard = 0;
        while (!resp_valid && guard < 100) begin @(negedge clk); guard++; end
        chk(resp_valid, req, "resp_valid", resp_valid, 1);
        chk(resp_status == es, req, "resp_status", resp_status, es);
        chk(resp_frame == ef, req, "resp_frame", resp_frame, ef);
        chk(nreads == er, req, "read count", nreads, er);
        for (int i = 0; i < hold; i++) begin
            if (poke) begin
                req_valid = 1'b1; req_vpn = 8'h11; req_dir_base = 32'h1000;
                stray_v = (i == 0); stray_d = 32'h8000_0ABC;
            end
            @(negedge clk);
            stray_v = 1'b0;
            chk(resp_valid && resp_status == es && resp_frame == ef, "R9/R8/R2",
                "held result", {resp_valid, resp_status, resp_frame}, {1'b1, es, ef});
        end
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0; req_valid = 1'b0;
        chk(req_ready && !resp_valid && nreads == er, "R9/R2", "back to idle",
            {req_ready, resp_valid}, 2'b10);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        mem[32'h100C] = 32'h8000_0050;   // chunk 0x50 -> 0x1400
        mem[32'h141C] = 32'h8001_2345;
        mem[32'h1438] = 32'h0000_7777;   // invalid entry, nonzero frame bits
        mem[32'h2000] = 32'h8000_0081;   // chunk -> 0x2040
        mem[32'h2040] = 32'h800F_FFFF;
        mem[32'h203C] = 32'h8000_00A0;   // chunk -> 0x2800
        mem[32'h283C] = 32'h8000_0001;
        mem[32'h3008] = 32'h0000_0050;   // invalid directory word

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(req_ready && !resp_valid && !mem_rd_en, "R1", "reset outputs",
            {req_ready, resp_valid, mem_rd_en}, 3'b100);

        // stray return while idle must be ignored
        @(negedge clk); stray_v = 1'b1; stray_d = 32'h8000_0050;
        @(negedge clk); stray_v = 1'b0;
        chk(req_ready && !mem_rd_en && !resp_valid, "R8", "stray in idle",
            {req_ready, mem_rd_en, resp_valid}, 3'b100);

        walk(8'h37, 32'h1000, 0, 0, 0, 2'b00, 20'h12345, 2, "R6 R4 R3 lat0");
        walk(8'h37, 32'h1000, 4, 2, 0, 2'b00, 20'h12345, 2, "R6 R8 lat4");
        walk(8'h5A, 32'h1000, 2, 0, 0, 2'b01, 20'h0,     1, "R5 absent chunk");
        walk(8'h22, 32'h3000, 1, 0, 0, 2'b01, 20'h0,     1, "R5 invalid dir bits");
        walk(8'h3C, 32'h1000, 0, 0, 0, 2'b10, 20'h0,     2, "R7 empty entry");
        walk(8'h3E, 32'h1000, 3, 0, 0, 2'b10, 20'h0,     2, "R7 invalid entry bits");
        walk(8'h00, 32'h2000, 1, 3, 1, 2'b00, 20'hFFFFF, 2, "R6 R2 vpn 00 poke");
        walk(8'hFF, 32'h2000, 6, 0, 0, 2'b00, 20'h00001, 2, "R4 R10 vpn FF");
        walk(8'h5A, 32'h1000, 0, 4, 1, 2'b01, 20'h0,     1, "R5 R9 poke");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule